// File: doc/BRIEF.md
# PCI Bridge System Error Reporter

This block gathers error events seen by a two-port PCI-to-PCI bridge and decides, cycle by cycle, whether the bridge should pull its primary system error line low. Each event arrives as a single-cycle pulse. The pulse carries an error kind, a transaction type, a direction and the bus on which the error was detected. The block weighs these against the command-register enable, the bridge-control forward enable and the two parity-response bits. It also forwards a system error raised on the secondary bus. That secondary input is resynchronised through a two-flop chain before it is used.

The system error line is open-drain. The output `serr_drive` is a pad enable: 1 means the pad pulls the line low, and 0 means the line is released to its pull-up. Two sticky status bits record what happened, and software clears each one by writing one to it. A per-transaction retry counter counts target retries on the transaction in flight. When the counter reaches its limit, the transaction is discarded; the block emits a one-cycle discard pulse and treats the discard as a system error condition. Event inputs are plain pulses with no back-pressure: every pulse is taken in the cycle it is presented, and nothing is queued.

Top module: `bridge_serr_reporter`

## Requirements
- R1: After reset, `serr_drive`, `sts_sig_serr`, `sts_rcv_serr` and `discard_pulse` are 0, and the retry count is zero.
- R2: While `cmd_serr_en` is 0 in a cycle, no source in that cycle sets `serr_drive` in the next cycle or sets `sts_sig_serr`.
- R3: An event with `err_kind` 0 (target abort) or 1 (master abort) on a posted write (`err_xact` 0) drives `serr_drive` in the cycle after the pulse. The same abort on a delayed write (1) or delayed read (2) has no effect.
- R4: A parity event (`err_kind` 2) on a posted write detected on the target bus counts as a condition only when both `pri_perr_resp` and `sec_perr_resp` are 1. The target bus is secondary (`err_bus` 1) for downstream (`err_dir` 0) and primary (`err_bus` 0) for upstream (`err_dir` 1).
- R5: A parity event on a delayed write or delayed read, or on a posted write detected on the initiator bus, never drives `serr_drive`. `err_kind` 3 and `err_xact` 3 are ignored.
- R6: When `sec_serr_in_n` is low, the line is asserted after the two-flop delay and one output register, provided `bctl_fwd_en` and `cmd_serr_en` are both 1. Each such forward also sets `sts_rcv_serr`. Without the forward enable, neither happens.
- R7: The RETRY_LIMIT-th `retry_hit` without an intervening `xact_done` produces a one-cycle `discard_pulse` with `discard_xact` equal to `retry_xact`. It also clears the count and asserts the line (if enabled), for any transaction type.
- R8: `xact_done` clears the retry count. When `xact_done` and `retry_hit` fall in the same cycle, the count is cleared and no discard is produced.
- R9: Whenever `serr_drive` is 1, `sts_sig_serr` is 1.
- R10: A write-one-clear pulse on `clr_sig_serr` or `clr_rcv_serr` clears its bit at the next edge. A set in the same cycle wins over the clear.
- R11: `serr_drive` is high for exactly the cycles that follow a cycle holding at least one enabled condition; it is not stretched further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_serr_en | input | 1 | Command-register system error enable |
| bctl_fwd_en | input | 1 | Bridge-control secondary error forward enable |
| pri_perr_resp | input | 1 | Primary parity-error response bit |
| sec_perr_resp | input | 1 | Secondary parity-error response bit |
| sec_serr_in_n | input | 1 | Asynchronous secondary system error, active low |
| err_valid | input | 1 | Error event pulse |
| err_kind | input | 2 | 0 target abort, 1 master abort, 2 parity, 3 unused |
| err_xact | input | 2 | 0 posted write, 1 delayed write, 2 delayed read, 3 unused |
| err_dir | input | 1 | 0 downstream, 1 upstream |
| err_bus | input | 1 | Detecting bus: 0 primary, 1 secondary |
| retry_hit | input | 1 | Target retry received for the transaction in flight |
| retry_xact | input | 2 | Type of the transaction being retried |
| xact_done | input | 1 | Transaction in flight completed |
| clr_sig_serr | input | 1 | Write-one-clear of `sts_sig_serr` |
| clr_rcv_serr | input | 1 | Write-one-clear of `sts_rcv_serr` |
| serr_drive | output | 1 | Pad pull-down enable for the primary system error line |
| sts_sig_serr | output | 1 | Sticky signaled system error status |
| sts_rcv_serr | output | 1 | Sticky received system error status (secondary) |
| discard_pulse | output | 1 | One-cycle retry-limit discard indication |
| discard_xact | output | 2 | Type of the discarded transaction |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a status bit being set and software clearing it. The second pair is the retry counter reaching its limit while the transaction completes or while an event pulse arrives. Directed cases line up a clear pulse with an abort, and an `xact_done` with the final retry. Random stimulus with a fixed seed then makes these collisions frequent, with a small retry limit so that discards recur. Each cycle the outputs are compared against a bench model built from the requirements: set wins over clear, completion wins over discard, and any enabled source asserts the line.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    EV_TABORT = 2'd0,
    EV_MABORT = 2'd1,
    EV_PARITY = 2'd2,
    EV_UNUSED = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    XT_POSTED = 2'd0,
    XT_DWRITE = 2'd1,
    XT_DREAD  = 2'd2,
    XT_UNUSED = 2'd3
  } xact_e;

  localparam logic DIR_DOWN = 1'b0;
  localparam logic BUS_PRI  = 1'b0;
  localparam logic BUS_SEC  = 1'b1;
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic dout_n
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout_n = chain[STAGES-1];
endmodule

// File: rtl/bsr_retry.sv
module bsr_retry #(
  parameter int RETRY_LIMIT = 2**24,
  localparam int CNT_W = (RETRY_LIMIT > 2) ? $clog2(RETRY_LIMIT) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       retry_hit,
  input  logic       xact_done,
  input  logic [1:0] retry_xact,
  output logic       disc,
  output logic [1:0] disc_xact
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  // completion takes priority over a retry in the same cycle
  assign disc      = retry_hit && !xact_done && (cnt == LAST);
  assign disc_xact = retry_xact;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt <= '0;
    else if (xact_done || disc) cnt <= '0;
    else if (retry_hit)         cnt <= cnt + 1'b1;
endmodule

// File: rtl/bsr_classify.sv
module bsr_classify
  import bsr_pkg::*;
(
  input  logic       err_valid,
  input  logic [1:0] err_kind,
  input  logic [1:0] err_xact,
  input  logic       err_dir,
  input  logic       err_bus,
  input  logic       pri_perr_resp,
  input  logic       sec_perr_resp,
  output logic       cond
);
  ev_kind_e kind;
  xact_e    xact;
  logic     target_bus;
  logic     posted;

  assign kind       = ev_kind_e'(err_kind);
  assign xact       = xact_e'(err_xact);
  assign posted     = (xact == XT_POSTED);
  // the target bus is the far side from the initiator
  assign target_bus = (err_dir == DIR_DOWN) ? BUS_SEC : BUS_PRI;

  always_comb begin
    cond = 1'b0;
    if (err_valid && posted) begin
      unique case (kind)
        EV_TABORT, EV_MABORT: cond = 1'b1;
        EV_PARITY:            cond = (err_bus == target_bus) && pri_perr_resp && sec_perr_resp;
        default:              cond = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bridge_serr_reporter.sv
module bridge_serr_reporter #(
  parameter int RETRY_LIMIT = 2**24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_serr_en,
  input  logic       bctl_fwd_en,
  input  logic       pri_perr_resp,
  input  logic       sec_perr_resp,
  input  logic       sec_serr_in_n,
  input  logic       err_valid,
  input  logic [1:0] err_kind,
  input  logic [1:0] err_xact,
  input  logic       err_dir,
  input  logic       err_bus,
  input  logic       retry_hit,
  input  logic [1:0] retry_xact,
  input  logic       xact_done,
  input  logic       clr_sig_serr,
  input  logic       clr_rcv_serr,
  output logic       serr_drive,
  output logic       sts_sig_serr,
  output logic       sts_rcv_serr,
  output logic       discard_pulse,
  output logic [1:0] discard_xact
);
  logic       sec_sync_n;
  logic       ev_cond;
  logic       disc;
  logic [1:0] disc_xact;
  logic       fwd;
  logic       fire;

  bsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_n  (sec_serr_in_n),
    .dout_n (sec_sync_n)
  );

  bsr_classify u_cls (
    .err_valid     (err_valid),
    .err_kind      (err_kind),
    .err_xact      (err_xact),
    .err_dir       (err_dir),
    .err_bus       (err_bus),
    .pri_perr_resp (pri_perr_resp),
    .sec_perr_resp (sec_perr_resp),
    .cond          (ev_cond)
  );

  bsr_retry #(.RETRY_LIMIT(RETRY_LIMIT)) u_retry (
    .clk        (clk),
    .rst_n      (rst_n),
    .retry_hit  (retry_hit),
    .xact_done  (xact_done),
    .retry_xact (retry_xact),
    .disc       (disc),
    .disc_xact  (disc_xact)
  );

  assign fwd  = cmd_serr_en && bctl_fwd_en && !sec_sync_n;
  assign fire = cmd_serr_en && (ev_cond || disc || fwd);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      serr_drive    <= 1'b0;
      sts_sig_serr  <= 1'b0;
      sts_rcv_serr  <= 1'b0;
      discard_pulse <= 1'b0;
      discard_xact  <= 2'd0;
    end else begin
      serr_drive    <= fire;
      sts_sig_serr  <= (sts_sig_serr && !clr_sig_serr) || fire;
      sts_rcv_serr  <= (sts_rcv_serr && !clr_rcv_serr) || fwd;
      discard_pulse <= disc;
      if (disc) discard_xact <= disc_xact;
    end
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_serr_en,
  input logic       bctl_fwd_en,
  input logic       err_valid,
  input logic [1:0] err_kind,
  input logic [1:0] err_xact,
  input logic       xact_done,
  input logic       serr_drive,
  input logic       sts_sig_serr,
  input logic       sts_rcv_serr,
  input logic       discard_pulse
);
  a_r2_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_serr_en |=> !serr_drive);

  a_r3_abort_posted: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_serr_en && err_valid && err_xact == 2'd0 && (err_kind == 2'd0 || err_kind == 2'd1))
      |=> serr_drive);

  a_r9_sig_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    serr_drive |-> sts_sig_serr);

  a_r6_rcv_needs_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rcv_serr) |-> $past(bctl_fwd_en && cmd_serr_en));

  a_r7_discard_single: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |=> !discard_pulse);

  a_r8_done_blocks_discard: assert property (@(posedge clk) disable iff (!rst_n)
    xact_done |=> !discard_pulse);
endmodule

bind bridge_serr_reporter bsr_checker u_chk (.*);

// File: tb/tb_bridge_serr_reporter.sv
module tb_bridge_serr_reporter;
  localparam int LIMIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_serr_en, bctl_fwd_en, pri_perr_resp, sec_perr_resp, sec_serr_in_n;
  logic err_valid, err_dir, err_bus, retry_hit, xact_done, clr_sig_serr, clr_rcv_serr;
  logic [1:0] err_kind, err_xact, retry_xact;
  logic serr_drive, sts_sig_serr, sts_rcv_serr, discard_pulse;
  logic [1:0] discard_xact;

  always #5 clk = ~clk;

  bridge_serr_reporter #(.RETRY_LIMIT(LIMIT)) dut (.*);

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  logic m_drive, m_sig, m_rcv, m_disc, m_s1, m_s2;
  logic [1:0] m_dx;
  int m_cnt;

  function automatic logic exp_cond(logic v, logic [1:0] k, logic [1:0] x, logic d, logic b,
                                    logic pr, logic sr);
    if (!v || x != 2'd0) return 1'b0;
    if (k == 2'd0 || k == 2'd1) return 1'b1;
    if (k == 2'd2) return (b == ~d) && pr && sr;
    return 1'b0;
  endfunction

  task automatic chk(string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk("serr_drive", serr_drive, m_drive);
    chk("sts_sig_serr", sts_sig_serr, m_sig);
    chk("sts_rcv_serr", sts_rcv_serr, m_rcv);
    chk("discard_pulse", discard_pulse, m_disc);
    if (m_disc) begin
      checks++;
      if (discard_xact !== m_dx) begin
        errors++;
        $display("FAIL %s discard_xact got %0d exp %0d", cur_req, discard_xact, m_dx);
      end
    end
  endtask

  task automatic model_update();
    logic fwd, disc, fire;
    fwd  = cmd_serr_en && bctl_fwd_en && !m_s2;
    disc = retry_hit && !xact_done && (m_cnt == LIMIT - 1);
    fire = cmd_serr_en && (fwd || disc ||
           exp_cond(err_valid, err_kind, err_xact, err_dir, err_bus, pri_perr_resp, sec_perr_resp));
    m_drive = fire;
    m_sig   = (m_sig && !clr_sig_serr) || fire;
    m_rcv   = (m_rcv && !clr_rcv_serr) || fwd;
    m_disc  = disc;
    if (disc) m_dx = retry_xact;
    if (xact_done || disc) m_cnt = 0;
    else if (retry_hit) m_cnt = m_cnt + 1;
    m_s2 = m_s1;
    m_s1 = sec_serr_in_n;
  endtask

  task automatic step();
    model_update();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    err_valid = 0; err_kind = 0; err_xact = 0; err_dir = 0; err_bus = 0;
    retry_hit = 0; retry_xact = 0; xact_done = 0;
    clr_sig_serr = 0; clr_rcv_serr = 0; sec_serr_in_n = 1;
  endtask

  task automatic ev(logic [1:0] k, logic [1:0] x, logic d, logic b);
    err_valid = 1; err_kind = k; err_xact = x; err_dir = d; err_bus = b;
    step();
    idle();
    step();
  endtask

  task automatic clear_all();
    clr_sig_serr = 1; clr_rcv_serr = 1;
    step();
    idle();
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    cmd_serr_en = 1; bctl_fwd_en = 1; pri_perr_resp = 1; sec_perr_resp = 1;
    m_drive = 0; m_sig = 0; m_rcv = 0; m_disc = 0; m_s1 = 1; m_s2 = 1; m_dx = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1;
    step();

    // abort on posted write, then on delayed transactions
    cur_req = "R3";
    ev(2'd0, 2'd0, 1'b0, 1'b0);
    ev(2'd1, 2'd0, 1'b1, 1'b1);
    clear_all();
    ev(2'd0, 2'd1, 1'b0, 1'b0);
    ev(2'd1, 2'd2, 1'b1, 1'b0);

    // parity on target bus with response bits
    cur_req = "R4";
    ev(2'd2, 2'd0, 1'b0, 1'b1);
    ev(2'd2, 2'd0, 1'b1, 1'b0);
    clear_all();
    pri_perr_resp = 0;
    ev(2'd2, 2'd0, 1'b0, 1'b1);
    pri_perr_resp = 1; sec_perr_resp = 0;
    ev(2'd2, 2'd0, 1'b1, 1'b0);
    sec_perr_resp = 1;

    cur_req = "R5";
    ev(2'd2, 2'd2, 1'b0, 1'b1);
    ev(2'd2, 2'd1, 1'b1, 1'b0);
    ev(2'd2, 2'd0, 1'b0, 1'b0);
    ev(2'd3, 2'd0, 1'b0, 1'b1);
    ev(2'd0, 2'd3, 1'b0, 1'b0);

    cur_req = "R2";
    cmd_serr_en = 0;
    ev(2'd0, 2'd0, 1'b0, 1'b0);
    sec_serr_in_n = 0; step(); idle(); repeat (3) step();
    cmd_serr_en = 1;

    // forwarding after the synchronizer
    cur_req = "R6";
    sec_serr_in_n = 0; step(); idle(); repeat (3) step();
    clear_all();
    bctl_fwd_en = 0;
    sec_serr_in_n = 0; step(); idle(); repeat (3) step();
    bctl_fwd_en = 1;

    // retry limit discard for each transaction type
    cur_req = "R7";
    for (int t = 0; t < 3; t++) begin
      retry_hit = 1; retry_xact = 2'(t);
      repeat (LIMIT) step();
      idle(); step();
      clear_all();
    end

    cur_req = "R8";
    retry_hit = 1; retry_xact = 2'd1;
    repeat (LIMIT - 1) step();
    xact_done = 1; step();
    xact_done = 0;
    repeat (LIMIT - 1) step();
    idle(); step();

    // clear colliding with a set
    cur_req = "R10";
    ev(2'd0, 2'd0, 1'b0, 1'b0);
    clr_sig_serr = 1; err_valid = 1; err_kind = 2'd1; err_xact = 2'd0;
    step(); idle(); step();
    clear_all(); step();

    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      if (i == 1500) cur_req = "R11";
      cmd_serr_en   = ($urandom_range(0, 99) < 85);
      bctl_fwd_en   = $urandom_range(0, 1);
      pri_perr_resp = ($urandom_range(0, 99) < 70);
      sec_perr_resp = ($urandom_range(0, 99) < 70);
      sec_serr_in_n = ($urandom_range(0, 99) >= 10);
      err_valid     = ($urandom_range(0, 99) < 40);
      err_kind      = 2'($urandom_range(0, 3));
      err_xact      = 2'($urandom_range(0, 3));
      err_dir       = $urandom_range(0, 1);
      err_bus       = $urandom_range(0, 1);
      retry_hit     = ($urandom_range(0, 99) < 45);
      retry_xact    = 2'($urandom_range(0, 2));
      xact_done     = ($urandom_range(0, 99) < 10);
      clr_sig_serr  = ($urandom_range(0, 99) < 25);
      clr_rcv_serr  = ($urandom_range(0, 99) < 25);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule